// File: doc/BRIEF.md
# Synchronous Serial Character Receiver

This block receives serial characters framed by start, data, parity and stop bits. It takes exactly one sample per bit, on each rising edge of an external bit clock. Both the bit clock and the data line come into the system clock domain through two-flop synchronizers. A rising edge of the synchronized bit clock produces a one-cycle sample strobe. The data line goes through the same number of stages, so each sample is the data value that was present when the bit clock rose.

When the receiver is idle, a low sample starts a frame. Configuration is captured at that start bit. The receiver then collects 5 to 9 data bits, least significant bit first. It takes a parity bit if parity is enabled, and then one or two stop bits. The finished character goes into a holding register and raises a ready flag. Reading the holding register clears the ready flag. Overrun, parity and framing problems set sticky flags, and a status-clear strobe resets all three.

Top module: `sync_char_rx`

## Requirements
- R1: The data line is sampled once for each rising edge of `ser_clk`, and at no other time. The internal sample strobe is never high on two cycles in a row.
- R2: While idle, a high sample is ignored and a low sample begins a frame. A stream of high samples leaves `rx_ready` and `rd_data` unchanged.
- R3: `cfg_len` sets the number of data bits: code 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits, and codes 5 to 7 give 9. The first data bit lands in `rd_data[0]`. Bits of `rd_data` above the character length read as 0.
- R4: When a character completes, it is written to `rd_data` and `rx_ready` is set on the next cycle.
- R5: If a character completes while `rx_ready` is set and no read is being made in that cycle, `ovr_err` is set. The new character replaces the old one.
- R6: `ovr_err`, `par_err` and `frm_err` stay set until a cycle with `sts_clr` high, which clears all three.
- R7: A cycle with `rd_stb` high clears `rx_ready`. If a read and a completion fall in the same cycle, `rx_ready` stays set, `rd_data` takes the new character, and `ovr_err` is not set.
- R8: `cfg_par` selects the parity mode: 0 none, 1 even, 2 odd, 3 forced 0, 4 forced 1, and codes 5 to 7 mean none. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number. In the forced modes the parity bit must equal the forced value. A mismatch sets `par_err`. With no parity, no parity bit is taken.
- R9: `cfg_stop2` set to 0 gives one stop bit, and set to 1 gives two. A low sample in any stop position sets `frm_err`. After the last stop bit the receiver is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | External bit clock, asynchronous to clk |
| ser_din | input | 1 | Serial data, sampled on ser_clk rising edges |
| cfg_len | input | 3 | Character length code |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| rd_stb | input | 1 | Read strobe for the holding register |
| sts_clr | input | 1 | Clears the overrun, parity and framing flags |
| rd_data | output | 9 | Holding register |
| rx_ready | output | 1 | Holding register holds an unread character |
| ovr_err | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Sticky parity-error flag |
| frm_err | output | 1 | Sticky framing-error flag |

## Verification
The read of the holding register and the completion of a new character can land in the same system clock cycle. In that case the read must not cancel the new ready and must not raise overrun. The bench provokes this by timing `rd_stb` a fixed number of system cycles after the rising edge of the final stop bit, to match the latency of the synchronizer and the frame logic. The character before it is left unread on purpose. The result is judged as correct when `rx_ready` is still high, `rd_data` holds the new character and `ovr_err` is still low.

// File: rtl/sync_char_rx_pkg.sv
package sync_char_rx_pkg;
  localparam int MAX_BITS = 9;
  localparam int CNT_W = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    PM_NONE = 3'd0,
    PM_EVEN = 3'd1,
    PM_ODD  = 3'd2,
    PM_ZERO = 3'd3,
    PM_ONE  = 3'd4
  } par_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_DATA, ST_PAR, ST_STOP
  } rx_state_t;

  function automatic par_mode_t decode_par(input logic [2:0] code);
    case (code)
      3'd1: decode_par = PM_EVEN;
      3'd2: decode_par = PM_ODD;
      3'd3: decode_par = PM_ZERO;
      3'd4: decode_par = PM_ONE;
      default: decode_par = PM_NONE;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] decode_len(input logic [2:0] code);
    if (code > 3'd4) decode_len = CNT_W'(MAX_BITS);
    else decode_len = CNT_W'(code) + CNT_W'(5);
  endfunction

  // acc is XOR of received data bits, pbit the received parity bit
  function automatic logic parity_bad(input par_mode_t m, input logic acc, input logic pbit);
    case (m)
      PM_EVEN: parity_bad = acc ^ pbit;
      PM_ODD:  parity_bad = ~(acc ^ pbit);
      PM_ZERO: parity_bad = pbit;
      PM_ONE:  parity_bad = ~pbit;
      default: parity_bad = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rx_sync_edge.sv
module rx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_din,
  output logic smp,
  output logic smp_bit
);
  logic [STAGES:0]   clk_q;
  logic [STAGES-1:0] din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= '0;
      din_q <= '1;
    end else begin
      clk_q <= {clk_q[STAGES-1:0], ser_clk};
      din_q <= {din_q[STAGES-2:0], ser_din};
    end
  end

  assign smp     = clk_q[STAGES-1] & ~clk_q[STAGES];
  assign smp_bit = din_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import sync_char_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                smp,
  input  logic                smp_bit,
  input  logic [2:0]          cfg_len,
  input  logic [2:0]          cfg_par,
  input  logic                cfg_stop2,
  output logic                done,
  output logic [MAX_BITS-1:0] done_data,
  output logic                done_perr,
  output logic                done_ferr
);
  rx_state_t           state;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    len_q;
  par_mode_t           mode_q;
  logic                stop2_q;
  logic                scnt;
  logic [MAX_BITS-1:0] shreg;
  logic                acc;
  logic                perr;
  logic                ferr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      len_q     <= CNT_W'(5);
      mode_q    <= PM_NONE;
      stop2_q   <= 1'b0;
      scnt      <= 1'b0;
      shreg     <= '0;
      acc       <= 1'b0;
      perr      <= 1'b0;
      ferr      <= 1'b0;
      done      <= 1'b0;
      done_data <= '0;
      done_perr <= 1'b0;
      done_ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (smp) begin
        case (state)
          ST_IDLE: if (!smp_bit) begin
            shreg   <= '0;
            acc     <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
            cnt     <= '0;
            len_q   <= decode_len(cfg_len);
            mode_q  <= decode_par(cfg_par);
            stop2_q <= cfg_stop2;
            state   <= ST_DATA;
          end
          ST_DATA: begin
            shreg[cnt] <= smp_bit;
            acc        <= acc ^ smp_bit;
            cnt        <= cnt + 1'b1;
            if (cnt == len_q - 1'b1) begin
              scnt  <= 1'b0;
              state <= (mode_q == PM_NONE) ? ST_STOP : ST_PAR;
            end
          end
          ST_PAR: begin
            perr  <= parity_bad(mode_q, acc, smp_bit);
            state <= ST_STOP;
          end
          ST_STOP: begin
            if (!smp_bit) ferr <= 1'b1;
            if (scnt == stop2_q) begin
              done      <= 1'b1;
              done_data <= shreg;
              done_perr <= perr;
              done_ferr <= ferr | ~smp_bit;
              state     <= ST_IDLE;
            end else begin
              scnt <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done,
  input  logic [W-1:0] done_data,
  input  logic         done_perr,
  input  logic         done_ferr,
  input  logic         rd_stb,
  input  logic         sts_clr,
  output logic [W-1:0] rd_data,
  output logic         rx_ready,
  output logic         ovr_err,
  output logic         par_err,
  output logic         frm_err
);
  logic set_ovr;
  assign set_ovr = done & rx_ready & ~rd_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rx_ready <= 1'b0;
      ovr_err  <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      if (done) begin
        rd_data  <= done_data;
        rx_ready <= 1'b1;
      end else if (rd_stb) begin
        rx_ready <= 1'b0;
      end
      ovr_err <= (ovr_err & ~sts_clr) | set_ovr;
      par_err <= (par_err & ~sts_clr) | (done & done_perr);
      frm_err <= (frm_err & ~sts_clr) | (done & done_ferr);
    end
  end
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
  import sync_char_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk,
  input  logic                ser_din,
  input  logic [2:0]          cfg_len,
  input  logic [2:0]          cfg_par,
  input  logic                cfg_stop2,
  input  logic                rd_stb,
  input  logic                sts_clr,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rx_ready,
  output logic                ovr_err,
  output logic                par_err,
  output logic                frm_err
);
  logic                smp;
  logic                smp_bit;
  logic                fr_done;
  logic [MAX_BITS-1:0] fr_data;
  logic                fr_perr;
  logic                fr_ferr;

  rx_sync_edge #(.STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .smp(smp), .smp_bit(smp_bit)
  );

  rx_frame i_frame (
    .clk(clk), .rst(rst), .smp(smp), .smp_bit(smp_bit),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .done(fr_done), .done_data(fr_data), .done_perr(fr_perr), .done_ferr(fr_ferr)
  );

  rx_hold #(.W(MAX_BITS)) i_hold (
    .clk(clk), .rst(rst), .done(fr_done), .done_data(fr_data),
    .done_perr(fr_perr), .done_ferr(fr_ferr), .rd_stb(rd_stb), .sts_clr(sts_clr),
    .rd_data(rd_data), .rx_ready(rx_ready), .ovr_err(ovr_err),
    .par_err(par_err), .frm_err(frm_err)
  );
endmodule

// File: rtl/sync_char_rx_chk.sv
module sync_char_rx_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic         smp,
  input logic         fr_done,
  input logic [W-1:0] fr_data,
  input logic         rd_stb,
  input logic         sts_clr,
  input logic [W-1:0] rd_data,
  input logic         rx_ready,
  input logic         ovr_err,
  input logic         par_err,
  input logic         frm_err
);
  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (rst) smp |=> !smp); // R1
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    fr_done |=> (rx_ready && rd_data == $past(fr_data))); // R4
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (fr_done && rx_ready && !rd_stb) |=> ovr_err); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_err && !sts_clr) |=> ovr_err); // R6
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sts_clr && !fr_done) |=> (!ovr_err && !par_err && !frm_err)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !fr_done) |=> !rx_ready); // R7
  AST_READ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && fr_done && !ovr_err && !sts_clr) |=> (rx_ready && !ovr_err)); // R7
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !fr_done |=> $stable(rd_data)); // R2
endmodule

bind sync_char_rx sync_char_rx_chk #(.W(sync_char_rx_pkg::MAX_BITS)) i_chk (
  .clk(clk), .rst(rst), .smp(smp), .fr_done(fr_done), .fr_data(fr_data),
  .rd_stb(rd_stb), .sts_clr(sts_clr), .rd_data(rd_data), .rx_ready(rx_ready),
  .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err)
);

// File: tb/test_sync_char_rx.sv
module test_sync_char_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b1;
  logic [2:0] cfg_len = 3'd3;
  logic [2:0] cfg_par = 3'd0;
  logic       cfg_stop2 = 1'b0;
  logic       rd_stb = 1'b0;
  logic       sts_clr = 1'b0;
  logic [8:0] rd_data;
  logic       rx_ready, ovr_err, par_err, frm_err;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [8:0] m_data = '0;
  logic m_ready = 0, m_ovr = 0, m_par = 0, m_frm = 0;

  always #10 clk = ~clk;

  sync_char_rx i_sync_char_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .rd_stb(rd_stb), .sts_clr(sts_clr), .rd_data(rd_data), .rx_ready(rx_ready),
    .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err)
  );

  function automatic int len_of(input logic [2:0] c);
    return (c > 3'd4) ? 9 : int'(c) + 5;
  endfunction

  function automatic logic [8:0] mask_of(input logic [8:0] d, input logic [2:0] c);
    logic [8:0] r;
    r = '0;
    for (int i = 0; i < 9; i++) if (i < len_of(c)) r[i] = d[i];
    return r;
  endfunction

  function automatic logic good_par(input logic [8:0] d, input logic [2:0] m);
    case (m)
      3'd1: return ^d;
      3'd2: return ~^d;
      3'd3: return 1'b0;
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit has_par(input logic [2:0] m);
    return (m >= 3'd1 && m <= 3'd4);
  endfunction

  task automatic check(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "rd_data", rd_data, m_data);
    check(req, "rx_ready", {8'd0, rx_ready}, {8'd0, m_ready});
    check(req, "ovr_err", {8'd0, ovr_err}, {8'd0, m_ovr});
    check(req, "par_err", {8'd0, par_err}, {8'd0, m_par});
    check(req, "frm_err", {8'd0, frm_err}, {8'd0, m_frm});
  endtask

  // one bit period: data set while ser_clk low, rise after 4 system cycles
  task automatic send_bit(input logic b, input bit rd_at_rise);
    @(negedge clk);
    ser_clk = 1'b0;
    ser_din = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    if (rd_at_rise) begin
      repeat (3) @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
    end else begin
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input logic [2:0] len, input logic [2:0] pm,
                            input logic st2, input bit bad_par, input bit bad_stop,
                            input bit rd_at_done);
    logic [8:0] md;
    md = mask_of(d, len);
    cfg_len = len; cfg_par = pm; cfg_stop2 = st2;
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < len_of(len); i++) send_bit(md[i], 1'b0);
    if (has_par(pm)) send_bit(good_par(md, pm) ^ bad_par, 1'b0);
    if (st2) send_bit(~bad_stop, 1'b0);
    send_bit(st2 ? 1'b1 : ~bad_stop, rd_at_done);
    send_bit(1'b1, 1'b0);
    if (m_ready && !rd_at_done) m_ovr = 1;
    m_ready = 1;
    m_data = md;
    if (has_par(pm) && bad_par) m_par = 1;
    if (bad_stop) m_frm = 1;
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    @(negedge clk);
    m_ready = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
    @(negedge clk);
    m_ovr = 0; m_par = 0; m_frm = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R4 reset");

    // R2: idle high samples are ignored
    for (int i = 0; i < 12; i++) send_bit(1'b1, 1'b0);
    check_all("R2 idle");

    // R3: 8 bits LSB first, no parity, one stop
    send_frame(9'h0A5, 3'd3, 3'd0, 1'b0, 0, 0, 0);
    check_all("R3 8bit");
    do_read();
    check_all("R7 read clears");

    // R3: 5-bit length, upper bits zero
    send_frame(9'h1FF, 3'd0, 3'd0, 1'b0, 0, 0, 0);
    check_all("R3 5bit");
    do_read();
    // R3: 9-bit via code 7
    send_frame(9'h155, 3'd7, 3'd1, 1'b1, 0, 0, 0);
    check_all("R3 9bit");

    // R5: second unread completion
    send_frame(9'h03C, 3'd2, 3'd2, 1'b0, 0, 0, 0);
    check_all("R5 overrun");
    do_read();
    check_all("R6 ovr sticky after read");
    do_clear();
    check_all("R6 clear");

    // R7: read in completion cycle with unread prior character
    send_frame(9'h011, 3'd3, 3'd0, 1'b0, 0, 0, 0);
    send_frame(9'h0E7, 3'd3, 3'd0, 1'b0, 0, 0, 1);
    check_all("R7 read at done");
    do_read();

    // R8: each parity mode bad
    for (int pm = 1; pm <= 4; pm++) begin
      send_frame(9'h0C3, 3'd3, 3'(pm), 1'b0, 1, 0, 0);
      check_all("R8 bad parity");
      do_read();
      do_clear();
      send_frame(9'h0C2, 3'd3, 3'(pm), 1'b0, 0, 0, 0);
      check_all("R8 good parity");
      do_read();
    end

    // R9: framing error in single and double stop
    send_frame(9'h05A, 3'd3, 3'd0, 1'b0, 0, 1, 0);
    check_all("R9 bad stop 1");
    do_read(); do_clear();
    send_frame(9'h05B, 3'd3, 3'd0, 1'b1, 0, 1, 0);
    check_all("R9 bad stop 2");
    do_read(); do_clear();
    send_frame(9'h06B, 3'd1, 3'd0, 1'b1, 0, 0, 0);
    check_all("R9 two stops ok");
    do_read();

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [2:0] l, p;
      bit bp, bs, rd;
      l = 3'($urandom_range(0, 7));
      p = 3'($urandom_range(0, 7));
      bp = ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 5) == 0);
      rd = ($urandom_range(0, 3) == 0);
      send_frame(9'($urandom), l, p, 1'($urandom), bp, bs, rd);
      check_all("R8 R9 random");
      if ($urandom_range(0, 1) == 1) do_read();
      if ($urandom_range(0, 3) == 0) do_clear();
      check_all("R6 R7 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule